// File: doc/BRIEF.md
# Banked Interrupt Distributor

This block collects interrupt sources for a small multi-core cluster and hands each core the most urgent request that is routed to it. Software configures it through 32-bit word reads and writes. Lines are grouped in banks of 32. IDs 0 to 15 are raised only by software. IDs 16 to 31 come from each core's own private inputs. IDs 32 and up come from shared peripheral inputs that can be routed to any set of cores.

Pending and active state for IDs 0 to 31 is kept once per core. A bus access carries the number of the requesting core, and that number selects which core's copy of the private IDs the access sees. Enable, priority and trigger mode are shared by all cores.

Each core gets a registered request flag with an ID. It acknowledges with a one-cycle pulse, which makes the ID active. It later ends the interrupt by giving the ID back.

Top module: `idist_top`

## Requirements
- R1: The three ID ranges behave as follows.
  - IDs 0–15 become pending only through the software-interrupt register. Their trigger field always reads as edge (word at 0xC00 reads 0xAAAAAAAA), and writes to it are ignored.
  - IDs 16–31 are driven by `ppi_in[c*16 + (ID-16)]` of core c only.
  - IDs 32 and up are driven by `spi_in[ID-32]`.
- R2: The word at 0x004 holds the bank count minus one in bits 4:0 and the core count minus one in bits 7:5. All other bits read 0. The control word at 0x000 resets to 0.
- R3: While control bit 0 is 0, every `cpu_req` is low one cycle later, whatever is pending.
- R4: Enables are set by writing 1s to the word at 0x100 + 4·bank and cleared by writing 1s to the word at 0x180 + 4·bank (bit = ID mod 32). Zero bits have no effect. Both words read back the enable bits, and IDs beyond the configured count read 0.
- R5: Pending bits follow the same layout, with set words at 0x200 and clear words at 0x280. A read returns the effective pending state. For IDs 0–31, both reads and writes act on the bank of the core given on `bus_core`.
- R6: Priority is one byte per ID at 0x400 + 4·(ID/4), in byte lane ID mod 4, keeping the low PRIO_W bits. The smaller value wins, and on a tie the lower ID wins.
- R7: Target bytes at 0x800 + 4·(ID/4) route a shared ID to core c when bit c is set. Bytes of IDs 0–31 read as 1 << `bus_core` and ignore writes.
- R8: Bit 2·(ID mod 16)+1 of the word at 0xC00 + 4·(ID/16) selects the trigger mode: 1 for edge, 0 for level. A level ID is pending while its input is high. An edge ID latches pending on a rising edge and stays pending until it is acknowledged or cleared.
- R9: Writing 0xF00 with an ID in bits 3:0 and a core list in bits 16+c marks that ID pending in the bank of each listed core only.
- R10: `cpu_req`/`cpu_id` are registered and follow state changes one cycle later.
  - An acknowledge pulse while `cpu_req` is high makes `cpu_id` active and clears its latched pending bit, and `cpu_req` is low in the following cycle.
  - An active ID is not forwarded again until its end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_core | input | CORE_W | Core issuing the bus access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data valid next cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| spi_in | input | NUM_IRQ-32 | Shared peripheral inputs |
| ppi_in | input | NUM_CORES*16 | Private peripheral inputs, 16 per core |
| cpu_req | output | NUM_CORES | Request per core |
| cpu_id | output | NUM_CORES*10 | Presented ID per core |
| cpu_ack | input | NUM_CORES | Acknowledge pulse per core |
| cpu_eoi | input | NUM_CORES | End-of-interrupt pulse per core |
| cpu_eoi_id | input | NUM_CORES*10 | ID being ended per core |

## Verification
The hardest case to reach is a level line that is still high when its end-of-interrupt arrives. The line must come straight back, while an edge line must not. The bench keeps a shared input asserted across acknowledge and end-of-interrupt, then repeats the sequence with a one-cycle pulse on an edge-configured neighbour. It also writes the software-interrupt register while giving one core as `bus_core` and reads the private pending word as each core in turn, so it can see that the two banks stay apart.

// File: rtl/idist_pkg.sv
package idist_pkg;
   localparam int ID_W     = 10;
   localparam int PRIV_IDS = 32;
   localparam int SW_IDS   = 16;
   localparam int ADDR_W   = 12;
   localparam int DATA_W   = 32;
endpackage

// File: rtl/idist_edge.sv
module idist_edge #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= din;
   end

   assign rise = din & ~prev_q;
endmodule

// File: rtl/idist_arb.sv
module idist_arb #(
   parameter int N  = 64,
   parameter int PW = 8,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  elig,
   input  logic [N*PW-1:0] prio,
   output logic          found,
   output logic [IW-1:0] best
);
   logic [PW-1:0] best_p;

   // strict less-than keeps the lower ID on equal priority
   always_comb begin
      found  = 1'b0;
      best   = '0;
      best_p = '1;
      for (int i = 0; i < N; i++) begin
         if (elig[i] && (!found || prio[i*PW +: PW] < best_p)) begin
            found  = 1'b1;
            best   = IW'(i);
            best_p = prio[i*PW +: PW];
         end
      end
   end

   a_r6_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> elig[best]);
   a_r6_idle_when_none: assert property (@(posedge clk) disable iff (!rst_n)
      !found |-> (elig == '0));
endmodule

// File: rtl/idist_top.sv
module idist_top
   import idist_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int NUM_CORES = 2,
   parameter int PRIO_W    = 8,
   parameter int NUM_IRQ   = 32 * NUM_BANKS,
   parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [CORE_W-1:0]         bus_core,
   input  logic                      bus_wr,
   input  logic                      bus_rd,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   input  logic [NUM_IRQ-33:0]       spi_in,
   input  logic [NUM_CORES*16-1:0]   ppi_in,
   output logic [NUM_CORES-1:0]      cpu_req,
   output logic [NUM_CORES*ID_W-1:0] cpu_id,
   input  logic [NUM_CORES-1:0]      cpu_ack,
   input  logic [NUM_CORES-1:0]      cpu_eoi,
   input  logic [NUM_CORES*ID_W-1:0] cpu_eoi_id
);
   localparam int NUM_SPI = NUM_IRQ - PRIV_IDS;
   localparam int IDX_W   = $clog2(NUM_IRQ);

   if (NUM_BANKS < 2 || NUM_BANKS > 32) begin : g_bad_banks
      $error("NUM_BANKS must be within 2..32");
   end
   if (NUM_CORES < 1 || NUM_CORES > 8) begin : g_bad_cores
      $error("NUM_CORES must be within 1..8");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must be within 1..8");
   end

   // ---------------- state ----------------
   logic                   ctl_en;
   logic [NUM_IRQ-1:0]     en_q;
   logic [PRIO_W-1:0]      prio_q   [NUM_IRQ];
   logic [NUM_CORES-1:0]   tgt_q    [NUM_SPI];
   logic [NUM_IRQ-1:16]    edge_q;
   logic [31:0]            pend_priv[NUM_CORES];
   logic [31:0]            act_priv [NUM_CORES];
   logic [NUM_SPI-1:0]     pend_spi;
   logic [NUM_SPI-1:0]     act_spi;
   logic [NUM_CORES-1:0]   cpu_req_q;
   logic [ID_W-1:0]        cpu_id_q [NUM_CORES];

   // ---------------- input edges ----------------
   logic [NUM_SPI-1:0]      spi_rise;
   logic [NUM_CORES*16-1:0] ppi_rise;

   idist_edge #(.W(NUM_SPI)) u_spi_edge (
      .clk(clk), .rst_n(rst_n), .din(spi_in), .rise(spi_rise));
   idist_edge #(.W(NUM_CORES*16)) u_ppi_edge (
      .clk(clk), .rst_n(rst_n), .din(ppi_in), .rise(ppi_rise));

   // ---------------- effective pending ----------------
   logic [31:0]        eff_priv [NUM_CORES];
   logic [NUM_SPI-1:0] eff_spi;

   always_comb begin
      for (int c = 0; c < NUM_CORES; c++) begin
         for (int k = 0; k < SW_IDS; k++) eff_priv[c][k] = pend_priv[c][k];
         for (int k = 0; k < 16; k++)
            eff_priv[c][16+k] = pend_priv[c][16+k] | (~edge_q[16+k] & ppi_in[c*16+k]);
      end
      for (int k = 0; k < NUM_SPI; k++)
         eff_spi[k] = pend_spi[k] | (~edge_q[32+k] & spi_in[k]);
   end

   // ---------------- address decode ----------------
   logic [9:0] w;
   logic r_ctl, r_type, r_sen, r_cen, r_spd, r_cpd, r_pri, r_tgt, r_cfg, r_sgi;
   assign w      = bus_addr[11:2];
   assign r_ctl  = (w == 10'h000);
   assign r_type = (w == 10'h001);
   assign r_sen  = (w[9:5] == 5'h02);
   assign r_cen  = (w[9:5] == 5'h03);
   assign r_spd  = (w[9:5] == 5'h04);
   assign r_cpd  = (w[9:5] == 5'h05);
   assign r_pri  = (w[9:8] == 2'b01);
   assign r_tgt  = (w[9:8] == 2'b10);
   assign r_cfg  = (w[9:6] == 4'b1100);
   assign r_sgi  = (w == 10'h3C0);

   // ---------------- read mux ----------------
   logic [DATA_W-1:0] rd_val;
   always_comb begin
      rd_val = '0;
      if (r_ctl)  rd_val[0] = ctl_en;
      if (r_type) rd_val[7:0] = {3'(NUM_CORES-1), 5'(NUM_BANKS-1)};
      for (int i = 0; i < NUM_IRQ; i++) begin
         if ((r_sen || r_cen) && (i/32) == int'(w[4:0])) rd_val[i%32] = en_q[i];
         if (r_pri && (i/4) == int'(w[7:0])) rd_val[(i%4)*8 +: PRIO_W] = prio_q[i];
      end
      for (int k = 0; k < NUM_SPI; k++) begin
         if ((r_spd || r_cpd) && ((32+k)/32) == int'(w[4:0])) rd_val[k%32] = eff_spi[k];
         if (r_tgt && ((32+k)/4) == int'(w[7:0])) rd_val[(k%4)*8 +: NUM_CORES] = tgt_q[k];
      end
      for (int i = 16; i < NUM_IRQ; i++)
         if (r_cfg && (i/16) == int'(w[5:0])) rd_val[(i%16)*2+1] = edge_q[i];
      if (r_cfg && w[5:0] == 6'd0)
         for (int k = 0; k < SW_IDS; k++) rd_val[k*2+1] = 1'b1;
      for (int c = 0; c < NUM_CORES; c++) begin
         if (bus_core == CORE_W'(c)) begin
            if ((r_spd || r_cpd) && w[4:0] == 5'd0) rd_val = eff_priv[c];
            if (r_tgt && w[7:0] < 8'd8)
               for (int b = 0; b < 4; b++) rd_val[b*8 + c] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
   end

   // ---------------- per-core selection ----------------
   logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
   logic [NUM_CORES-1:0]      found_w;
   logic [IDX_W-1:0]          best_w [NUM_CORES];

   always_comb
      for (int i = 0; i < NUM_IRQ; i++) prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic [NUM_IRQ-1:0] elig;
      always_comb begin
         for (int k = 0; k < 32; k++)
            elig[k] = ctl_en & en_q[k] & eff_priv[c][k] & ~act_priv[c][k];
         for (int k = 0; k < NUM_SPI; k++)
            elig[32+k] = ctl_en & en_q[32+k] & eff_spi[k] & ~act_spi[k] & tgt_q[k][c];
      end

      idist_arb #(.N(NUM_IRQ), .PW(PRIO_W), .IW(IDX_W)) u_arb (
         .clk(clk), .rst_n(rst_n), .elig(elig), .prio(prio_flat),
         .found(found_w[c]), .best(best_w[c]));

      assign cpu_id[c*ID_W +: ID_W] = cpu_id_q[c];

      a_r10_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_ack[c] && cpu_req_q[c]) |=> !cpu_req_q[c]);
      a_r10_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
         cpu_req_q[c] |-> (cpu_id_q[c] < ID_W'(NUM_IRQ)));
      a_r10_idle_id_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !cpu_req_q[c] |-> (cpu_id_q[c] == '0));
   end

   assign cpu_req = cpu_req_q;

   a_r3_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |=> (cpu_req_q == '0));

   // ---------------- state update ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en    <= 1'b0;
         en_q      <= '0;
         edge_q    <= '0;
         pend_spi  <= '0;
         act_spi   <= '0;
         cpu_req_q <= '0;
         for (int i = 0; i < NUM_IRQ; i++) prio_q[i] <= '0;
         for (int k = 0; k < NUM_SPI; k++) tgt_q[k] <= '0;
         for (int c = 0; c < NUM_CORES; c++) begin
            pend_priv[c] <= '0;
            act_priv[c]  <= '0;
            cpu_id_q[c]  <= '0;
         end
      end else begin
         // rising edges on edge-configured inputs latch pending
         for (int k = 0; k < NUM_SPI; k++)
            if (edge_q[32+k] && spi_rise[k]) pend_spi[k] <= 1'b1;
         for (int c = 0; c < NUM_CORES; c++)
            for (int k = 0; k < 16; k++)
               if (edge_q[16+k] && ppi_rise[c*16+k]) pend_priv[c][16+k] <= 1'b1;

         // acknowledge and end-of-interrupt
         for (int c = 0; c < NUM_CORES; c++) begin
            if (cpu_ack[c] && cpu_req_q[c]) begin
               for (int k = 0; k < 32; k++)
                  if (cpu_id_q[c] == ID_W'(k)) begin
                     act_priv[c][k]  <= 1'b1;
                     pend_priv[c][k] <= 1'b0;
                  end
               for (int k = 0; k < NUM_SPI; k++)
                  if (cpu_id_q[c] == ID_W'(32+k)) begin
                     act_spi[k]  <= 1'b1;
                     pend_spi[k] <= 1'b0;
                  end
            end
            if (cpu_eoi[c]) begin
               for (int k = 0; k < 32; k++)
                  if (cpu_eoi_id[c*ID_W +: ID_W] == ID_W'(k)) act_priv[c][k] <= 1'b0;
               for (int k = 0; k < NUM_SPI; k++)
                  if (cpu_eoi_id[c*ID_W +: ID_W] == ID_W'(32+k)) act_spi[k] <= 1'b0;
            end
            cpu_req_q[c] <= found_w[c] & ~cpu_ack[c];
            cpu_id_q[c]  <= (found_w[c] && !cpu_ack[c]) ? ID_W'(best_w[c]) : '0;
         end

         // register writes
         if (bus_wr) begin
            if (r_ctl) ctl_en <= bus_wdata[0];
            for (int i = 0; i < NUM_IRQ; i++) begin
               if (r_sen && (i/32) == int'(w[4:0]) && bus_wdata[i%32]) en_q[i] <= 1'b1;
               if (r_cen && (i/32) == int'(w[4:0]) && bus_wdata[i%32]) en_q[i] <= 1'b0;
               if (r_pri && (i/4) == int'(w[7:0])) prio_q[i] <= bus_wdata[(i%4)*8 +: PRIO_W];
            end
            for (int k = 0; k < NUM_SPI; k++) begin
               if (r_spd && ((32+k)/32) == int'(w[4:0]) && bus_wdata[k%32]) pend_spi[k] <= 1'b1;
               if (r_cpd && ((32+k)/32) == int'(w[4:0]) && bus_wdata[k%32]) pend_spi[k] <= 1'b0;
               if (r_tgt && ((32+k)/4) == int'(w[7:0])) tgt_q[k] <= bus_wdata[(k%4)*8 +: NUM_CORES];
            end
            for (int i = 16; i < NUM_IRQ; i++)
               if (r_cfg && (i/16) == int'(w[5:0])) edge_q[i] <= bus_wdata[(i%16)*2+1];
            for (int c = 0; c < NUM_CORES; c++) begin
               if (bus_core == CORE_W'(c) && w[4:0] == 5'd0)
                  for (int k = 0; k < 32; k++) begin
                     if (r_spd && bus_wdata[k]) pend_priv[c][k] <= 1'b1;
                     if (r_cpd && bus_wdata[k]) pend_priv[c][k] <= 1'b0;
                  end
               if (r_sgi && bus_wdata[16+c])
                  for (int k = 0; k < SW_IDS; k++)
                     if (bus_wdata[3:0] == 4'(k)) pend_priv[c][k] <= 1'b1;
            end
         end
      end
   end
endmodule

// File: tb/sim_idist_top.sv
module sim_idist_top;
   localparam int NB = 2;
   localparam int NC = 2;
   localparam int NI = 32 * NB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [0:0]    bus_core = '0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NI-33:0] spi_in = '0;
   logic [NC*16-1:0] ppi_in = '0;
   logic [NC-1:0] cpu_req;
   logic [NC*10-1:0] cpu_id;
   logic [NC-1:0] cpu_ack = '0, cpu_eoi = '0;
   logic [NC*10-1:0] cpu_eoi_id = '0;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   idist_top #(.NUM_BANKS(NB), .NUM_CORES(NC), .PRIO_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_core(bus_core), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_in(spi_in), .ppi_in(ppi_in), .cpu_req(cpu_req), .cpu_id(cpu_id),
      .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .cpu_eoi_id(cpu_eoi_id));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(int core, logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_core = 1'(core); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(int core, logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_core = 1'(core); bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic ack(int c);
      @(negedge clk); cpu_ack[c] = 1'b1;
      @(negedge clk); cpu_ack[c] = 1'b0;
   endtask

   task automatic eoi(int c, int id);
      @(negedge clk); cpu_eoi[c] = 1'b1; cpu_eoi_id[c*10 +: 10] = 10'(id);
      @(negedge clk); cpu_eoi[c] = 1'b0;
   endtask

   function automatic logic [31:0] req_id(int c);
      return {21'd0, cpu_req[c], cpu_id[c*10 +: 10]};
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      chk("R10 reset cpu_req", 32'(cpu_req), 32'h0);
      rd(0, 12'h004, d); chk("R2 type word", d, 32'h21);
      rd(0, 12'h000, d); chk("R2 control reset", d, 32'h0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(0, 12'h100, 32'h5);
      rd(0, 12'h180, d); chk("R4 set-enable readback", d, 32'h5);
      wr(0, 12'h180, 32'h1);
      rd(0, 12'h100, d); chk("R4 clear-enable", d, 32'h4);
      wr(0, 12'h100, 32'h0);
      rd(0, 12'h100, d); chk("R4 zero write no effect", d, 32'h4);
      wr(0, 12'h108, 32'hFFFF_FFFF);
      rd(0, 12'h108, d); chk("R4 unimplemented bank", d, 32'h0);
      wr(0, 12'h180, 32'hFFFF_FFFF);
   endtask

   task automatic t_level_edge();
      logic [31:0] d;
      wr(0, 12'h000, 32'h1);
      wr(0, 12'h104, 32'h300);       // IDs 40,41
      wr(0, 12'h828, 32'h0202);      // both to core 1
      wr(0, 12'hC08, 32'h0008_0000); // ID 41 edge
      spi_in[8] = 1'b1; settle();
      chk("R8 level forwarded core1", req_id(1), {21'd0, 1'b1, 10'd40});
      chk("R7 not routed core0", 32'(cpu_req[0]), 32'h0);
      ack(1);
      chk("R10 ack drops req", 32'(cpu_req[1]), 32'h0);
      settle();
      chk("R10 active not re-forwarded", 32'(cpu_req[1]), 32'h0);
      eoi(1, 40); settle();
      chk("R8 level still high after eoi", req_id(1), {21'd0, 1'b1, 10'd40});
      ack(1); spi_in[8] = 1'b0; eoi(1, 40); settle();
      chk("R8 level low not pending", 32'(cpu_req[1]), 32'h0);
      @(negedge clk); spi_in[9] = 1'b1; @(negedge clk); spi_in[9] = 1'b0;
      settle();
      chk("R8 edge latched", req_id(1), {21'd0, 1'b1, 10'd41});
      rd(0, 12'h204, d); chk("R5 pending read", d, 32'h200);
      wr(0, 12'h284, 32'h200); settle();
      chk("R5 clear pending", 32'(cpu_req[1]), 32'h0);
      @(negedge clk); spi_in[9] = 1'b1; @(negedge clk); spi_in[9] = 1'b0;
      settle(); ack(1); eoi(1, 41); settle();
      chk("R8 edge cleared by ack", 32'(cpu_req[1]), 32'h0);
      rd(0, 12'h204, d); chk("R5 pending after ack", d, 32'h0);
   endtask

   task automatic t_priority();
      logic [31:0] d;
      wr(0, 12'h104, 32'h3000);      // IDs 44,45
      wr(0, 12'h82C, 32'h0101);      // to core 0
      wr(0, 12'h42C, 32'h1020);      // 44=0x20, 45=0x10
      rd(0, 12'h42C, d); chk("R6 priority readback", d, 32'h1020);
      spi_in[12] = 1'b1; spi_in[13] = 1'b1; settle();
      chk("R6 lower value wins", req_id(0), {21'd0, 1'b1, 10'd45});
      wr(0, 12'h42C, 32'h1010); settle();
      chk("R6 tie lower ID", req_id(0), {21'd0, 1'b1, 10'd44});
      spi_in[12] = 1'b0; spi_in[13] = 1'b0; settle();
      chk("R8 level released", 32'(cpu_req[0]), 32'h0);
   endtask

   task automatic t_sgi();
      logic [31:0] d;
      rd(0, 12'hC00, d); chk("R1 software IDs edge", d, 32'hAAAA_AAAA);
      wr(0, 12'hC00, 32'h0);
      rd(0, 12'hC00, d); chk("R1 cfg write ignored", d, 32'hAAAA_AAAA);
      wr(0, 12'h100, 32'h0800_0008); // IDs 3,27
      wr(0, 12'hF00, 32'h0002_0003);
      settle();
      chk("R9 sgi to core1", req_id(1), {21'd0, 1'b1, 10'd3});
      chk("R9 core0 untouched", 32'(cpu_req[0]), 32'h0);
      rd(1, 12'h200, d); chk("R5 bank core1", d, 32'h8);
      rd(0, 12'h200, d); chk("R5 bank core0", d, 32'h0);
      ack(1); eoi(1, 3);
   endtask

   task automatic t_ppi();
      logic [31:0] d;
      ppi_in[11] = 1'b1; settle();
      chk("R1 private line core0", req_id(0), {21'd0, 1'b1, 10'd27});
      chk("R1 private not core1", 32'(cpu_req[1]), 32'h0);
      rd(1, 12'h818, d); chk("R7 private target read", d, 32'h0202_0202);
      wr(0, 12'h000, 32'h0); settle();
      chk("R3 forwarding off", 32'(cpu_req), 32'h0);
      wr(0, 12'h000, 32'h1); settle();
      chk("R3 forwarding back", req_id(0), {21'd0, 1'b1, 10'd27});
      ppi_in[11] = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R10 actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_enable();
      t_level_edge();
      t_priority();
      t_sgi();
      t_ppi();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule